// File: doc/BRIEF.md
# Vectored IRQ Handler Address Fetch Unit

This unit sits on the processor side of the link to an external vectored interrupt controller. It conditions the two active-low interrupt request lines, reporting them to the core as active-high pending flags. Each line passes through a two-stage synchronizer, and a strap input can bypass both synchronizers together. When the core enters an IRQ exception, the unit fetches the handler address from the controller instead of using the fixed IRQ exception vector. The fetch runs as a four-phase acknowledge/valid handshake. The address-valid input has its own synchronizer, bypassed by a second strap.

The core signals an exception entry with a one-cycle `irq_entry` or `fiq_entry` pulse. The unit answers with a one-cycle `target_ready` pulse, and the 32-bit handler target appears on `target_addr`. FIQ entries always get the fixed FIQ vector. IRQ entries get the fixed IRQ vector when vectored mode is off. With vectored mode on, an IRQ entry gets the word-aligned address supplied by the controller. `high_vectors` selects the low (0x0000_00xx) or high (0xFFFF_00xx) fixed vector base.

The handshake state machine has three states:
- `HS_IDLE`: no fetch in progress.
- `HS_REQ`: acknowledge is high and the unit waits for valid.
- `HS_RELEASE`: acknowledge has dropped and the unit waits for valid to return low.

It has three transitions:
- `HS_IDLE -> HS_REQ` on an IRQ entry in vectored mode with no FIQ entry in the same cycle.
- `HS_REQ -> HS_RELEASE` on the first cycle the conditioned valid is seen high.
- `HS_RELEASE -> HS_IDLE` once the conditioned valid is seen low.

Top module: `vic_vector_fetch`

## Requirements
- R1: With `req_sync_bypass` low, `irq_pending` equals the inverse of `norm_req_n` and `fiq_pending` equals the inverse of `fast_req_n`, each delayed by two rising clock edges.
- R2: With `req_sync_bypass` high, `irq_pending` and `fiq_pending` follow the inverted raw request inputs in the same cycle, with no clock edge in between.
- R3: The address-valid input is conditioned on its own. With `valid_sync_bypass` low, a change on `vec_valid` is seen by the state machine two edges later. With it high, the change is seen directly, so the capture and the acknowledge drop occur on the first rising edge after `vec_valid` rises.
- R4: An IRQ entry in vectored mode in `HS_IDLE` raises `vec_ack` after the next rising edge. `vec_ack` stays high for as long as the conditioned valid is low. It falls on the same edge that raises `target_ready`.
- R5: The target is captured on the edge that first observes conditioned valid high while in `HS_REQ`. It equals `{vec_addr_hi, 2'b00}`. Later changes on `vec_addr_hi` leave `target_addr` unchanged.
- R6: In `HS_RELEASE` no new acknowledge is raised, and an IRQ entry pulse is ignored. The unit returns to `HS_IDLE` only after conditioned valid is low.
- R7: An IRQ entry with `vectored_en` low produces `target_ready` one edge later with target 0x0000_0018, or 0xFFFF_0018 when `high_vectors` is high. `vec_ack` is never raised for it.
- R8: A FIQ entry produces `target_ready` one edge later with target 0x0000_001C, or 0xFFFF_001C when `high_vectors` is high. It never raises `vec_ack` and wins over an IRQ entry in the same cycle.
- R9: Synchronous active-low reset sets the state to `HS_IDLE` and clears `vec_ack`, `target_ready` and `target_addr`. It also sets the synchronizers to the idle level of their inputs.
- R10: Every accepted entry yields exactly one single-cycle `target_ready` pulse, and no pulse occurs without an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_req_n | input | 1 | Active-low fast interrupt request from the controller |
| norm_req_n | input | 1 | Active-low normal interrupt request from the controller |
| req_sync_bypass | input | 1 | Strap: bypass both request synchronizers |
| valid_sync_bypass | input | 1 | Strap: bypass the address-valid synchronizer |
| vec_ack | output | 1 | Active-high acknowledge requesting the vector address |
| vec_valid | input | 1 | Active-high: address bus is valid and held |
| vec_addr_hi | input | 30 | Handler address bits 31:2 |
| vectored_en | input | 1 | Use fetched vector for IRQ entry when high |
| high_vectors | input | 1 | Select the 0xFFFF_0000 fixed vector base |
| irq_entry | input | 1 | One-cycle pulse from the core: IRQ entry |
| fiq_entry | input | 1 | One-cycle pulse from the core: FIQ entry |
| fiq_pending | output | 1 | Conditioned fast request, active high |
| irq_pending | output | 1 | Conditioned normal request, active high |
| target_ready | output | 1 | One-cycle pulse: handler target valid |
| target_addr | output | 32 | Handler target address |

## Verification
The unit's results fall due at different times:
- Pending flags: two rising edges after a request change with the synchronizers in use, and at once with them bypassed.
- Fixed-vector answers: one edge after the entry pulse.
- Acknowledge: rises one edge after a vectored entry.
- Acknowledge drop and capture: three edges after `vec_valid` rises with synchronization, one edge when bypassed.

The bench drives inputs on falling edges and reads outputs on the following falling edges, so that each read lands exactly after the counted number of rising edges. A scoreboard queue gets an expected target whenever an entry is driven. A monitor compares it against each `target_ready` pulse on the falling edge after that pulse appears, and it flags any pulse that has no entry waiting.

// File: rtl/vvf_pkg.sv
package vvf_pkg;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_REQ     = 2'd1,
        HS_RELEASE = 2'd2
    } hs_state_e;

    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned VEC_W       = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] BASE_LOW  = 32'h0000_0000;
    localparam logic [ADDR_W-1:0] BASE_HIGH = 32'hFFFF_0000;
    localparam logic [ADDR_W-1:0] OFS_IRQ   = 32'h0000_0018;
    localparam logic [ADDR_W-1:0] OFS_FIQ   = 32'h0000_001C;

endpackage

// File: rtl/vvf_sync.sv
module vvf_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = bypass ? din : chain[STAGES-1];

endmodule

// File: rtl/vvf_fixed_vec.sv
module vvf_fixed_vec
    import vvf_pkg::*;
(
    input  logic              high_vectors,
    output logic [ADDR_W-1:0] irq_fixed,
    output logic [ADDR_W-1:0] fiq_fixed
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base      = high_vectors ? BASE_HIGH : BASE_LOW;
        irq_fixed = base | OFS_IRQ;
        fiq_fixed = base | OFS_FIQ;
    end

endmodule

// File: rtl/vvf_handshake_fsm.sv
module vvf_handshake_fsm
    import vvf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_entry,
    input  logic              fiq_entry,
    input  logic              vectored_en,
    input  logic              valid_s,
    input  logic [VEC_W-1:0]  vec_addr_hi,
    input  logic [ADDR_W-1:0] irq_fixed,
    input  logic [ADDR_W-1:0] fiq_fixed,
    output logic              ack_q,
    output logic              ready_q,
    output logic [ADDR_W-1:0] target_q
);
    hs_state_e state, state_nx;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE:    if (!fiq_entry && irq_entry && vectored_en) state_nx = HS_REQ;
            HS_REQ:     if (valid_s)  state_nx = HS_RELEASE;
            HS_RELEASE: if (!valid_s) state_nx = HS_IDLE;
            default:    state_nx = HS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            ready_q  <= 1'b0;
            target_q <= '0;
        end else begin
            ready_q <= 1'b0;
            unique case (state)
                HS_IDLE: begin
                    if (fiq_entry) begin
                        ready_q  <= 1'b1;
                        target_q <= fiq_fixed;
                    end else if (irq_entry) begin
                        if (vectored_en) begin
                            ack_q <= 1'b1;
                        end else begin
                            ready_q  <= 1'b1;
                            target_q <= irq_fixed;
                        end
                    end
                end
                HS_REQ: begin
                    if (valid_s) begin
                        ack_q    <= 1'b0;
                        ready_q  <= 1'b1;
                        target_q <= {vec_addr_hi, 2'b00};
                    end
                end
                HS_RELEASE: begin
                    ack_q <= 1'b0;
                end
                default: ack_q <= 1'b0;
            endcase
        end
    end

    AST_ACK_DROP_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> ready_q); // R4
    AST_ACK_HELD_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !valid_s) |=> ack_q); // R4
    AST_TARGET_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && $past(ack_q)) |-> (target_q[1:0] == 2'b00)); // R5
    AST_NO_ACK_IN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_RELEASE) |=> !ack_q); // R6
    AST_ACK_NEEDS_VECTORED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(vectored_en)); // R7
    AST_FIQ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_entry && !ack_q) |=> !ack_q); // R8

endmodule

// File: rtl/vic_vector_fetch.sv
module vic_vector_fetch
    import vvf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_req_n,
    input  logic              norm_req_n,
    input  logic              req_sync_bypass,
    input  logic              valid_sync_bypass,
    output logic              vec_ack,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec_addr_hi,
    input  logic              vectored_en,
    input  logic              high_vectors,
    input  logic              irq_entry,
    input  logic              fiq_entry,
    output logic              fiq_pending,
    output logic              irq_pending,
    output logic              target_ready,
    output logic [ADDR_W-1:0] target_addr
);
    logic fast_s, norm_s, valid_s;
    logic [ADDR_W-1:0] irq_fixed, fiq_fixed;

    vvf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fast_sync (
        .clk(clk), .rst_n(rst_n), .bypass(req_sync_bypass),
        .din(fast_req_n), .dout(fast_s));

    vvf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_norm_sync (
        .clk(clk), .rst_n(rst_n), .bypass(req_sync_bypass),
        .din(norm_req_n), .dout(norm_s));

    vvf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_valid_sync (
        .clk(clk), .rst_n(rst_n), .bypass(valid_sync_bypass),
        .din(vec_valid), .dout(valid_s));

    vvf_fixed_vec u_fixed (
        .high_vectors(high_vectors),
        .irq_fixed(irq_fixed),
        .fiq_fixed(fiq_fixed));

    vvf_handshake_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .irq_entry(irq_entry), .fiq_entry(fiq_entry),
        .vectored_en(vectored_en), .valid_s(valid_s),
        .vec_addr_hi(vec_addr_hi),
        .irq_fixed(irq_fixed), .fiq_fixed(fiq_fixed),
        .ack_q(vec_ack), .ready_q(target_ready), .target_q(target_addr));

    assign fiq_pending = ~fast_s;
    assign irq_pending = ~norm_s;

    AST_PENDING_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_sync_bypass |-> (irq_pending == !norm_req_n)); // R2

endmodule

// File: tb/vic_vector_fetch_test.sv
module vic_vector_fetch_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fast_req_n, norm_req_n, req_sync_bypass, valid_sync_bypass;
    logic        vec_ack, vec_valid;
    logic [29:0] vec_addr_hi;
    logic        vectored_en, high_vectors, irq_entry, fiq_entry;
    logic        fiq_pending, irq_pending, target_ready;
    logic [31:0] target_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_vector_fetch uut (
        .clk(clk), .rst_n(rst_n),
        .fast_req_n(fast_req_n), .norm_req_n(norm_req_n),
        .req_sync_bypass(req_sync_bypass), .valid_sync_bypass(valid_sync_bypass),
        .vec_ack(vec_ack), .vec_valid(vec_valid), .vec_addr_hi(vec_addr_hi),
        .vectored_en(vectored_en), .high_vectors(high_vectors),
        .irq_entry(irq_entry), .fiq_entry(fiq_entry),
        .fiq_pending(fiq_pending), .irq_pending(irq_pending),
        .target_ready(target_ready), .target_addr(target_addr));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic expect_target(input logic [31:0] a, input string req);
        exp_q.push_back(a);
        tag_q.push_back(req);
    endtask

    // monitor: compare each ready pulse with the scoreboard (R10)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && target_ready === 1'b1) begin
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R10 unexpected ready act=%h exp=none", target_addr);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, target_addr, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R4 watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fast_req_n = 1'b1; norm_req_n = 1'b1;
        req_sync_bypass = 1'b0; valid_sync_bypass = 1'b0;
        vec_valid = 1'b0; vec_addr_hi = '0;
        vectored_en = 1'b1; high_vectors = 1'b0;
        irq_entry = 1'b0; fiq_entry = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", {31'd0, vec_ack}, 32'd0);
        chk("R9", {31'd0, target_ready}, 32'd0);
        chk("R9", target_addr, 32'd0);
        chk("R9", {31'd0, irq_pending}, 32'd0);
        rst_n = 1'b1;

        // R1: two-edge synchronizer latency
        @(negedge clk) norm_req_n = 1'b0;
        @(negedge clk) chk("R1", {31'd0, irq_pending}, 32'd0);
        @(negedge clk) chk("R1", {31'd0, irq_pending}, 32'd1);
        fast_req_n = 1'b0;
        @(negedge clk) chk("R1", {31'd0, fiq_pending}, 32'd0);
        @(negedge clk) chk("R1", {31'd0, fiq_pending}, 32'd1);

        // R2: bypassed requests follow at once
        req_sync_bypass = 1'b1;
        norm_req_n = 1'b1; #1 chk("R2", {31'd0, irq_pending}, 32'd0);
        fast_req_n = 1'b1; #1 chk("R2", {31'd0, fiq_pending}, 32'd0);
        norm_req_n = 1'b0; #1 chk("R2", {31'd0, irq_pending}, 32'd1);
        norm_req_n = 1'b1; req_sync_bypass = 1'b0;
        repeat (3) @(negedge clk);

        // R7: fixed IRQ vectors, no handshake
        vectored_en = 1'b0;
        expect_target(32'h0000_0018, "R7");
        irq_entry = 1'b1;
        @(negedge clk) irq_entry = 1'b0;
        chk("R7", {31'd0, vec_ack}, 32'd0);
        high_vectors = 1'b1;
        expect_target(32'hFFFF_0018, "R7");
        irq_entry = 1'b1;
        @(negedge clk) irq_entry = 1'b0;
        chk("R7", {31'd0, vec_ack}, 32'd0);

        // R8: FIQ fixed vectors, priority over IRQ
        vectored_en = 1'b1; high_vectors = 1'b0;
        expect_target(32'h0000_001C, "R8");
        fiq_entry = 1'b1; irq_entry = 1'b1;
        @(negedge clk) begin fiq_entry = 1'b0; irq_entry = 1'b0; end
        chk("R8", {31'd0, vec_ack}, 32'd0);
        high_vectors = 1'b1;
        expect_target(32'hFFFF_001C, "R8");
        fiq_entry = 1'b1;
        @(negedge clk) fiq_entry = 1'b0;
        chk("R8", {31'd0, vec_ack}, 32'd0);
        high_vectors = 1'b0;
        @(negedge clk);

        // R4/R5: vectored fetch with synchronized valid
        irq_entry = 1'b1;
        @(negedge clk) irq_entry = 1'b0;
        chk("R4", {31'd0, vec_ack}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) chk("R4", {31'd0, vec_ack}, 32'd1);
        end
        vec_addr_hi = 30'h0ABC_DEF1;
        vec_valid = 1'b1;
        expect_target({30'h0ABC_DEF1, 2'b00}, "R5");
        @(negedge clk) chk("R3", {31'd0, vec_ack}, 32'd1);
        @(negedge clk) chk("R3", {31'd0, vec_ack}, 32'd1);
        @(negedge clk) chk("R4", {31'd0, vec_ack}, 32'd0);
        @(negedge clk) chk("R10", {31'd0, target_ready}, 32'd0);

        // R6/R5: entry in release ignored, held target unchanged
        vec_addr_hi = 30'h3FFF_FFFF;
        irq_entry = 1'b1;
        @(negedge clk) irq_entry = 1'b0;
        chk("R6", {31'd0, vec_ack}, 32'd0);
        chk("R5", target_addr, {30'h0ABC_DEF1, 2'b00});
        @(negedge clk) chk("R6", {31'd0, vec_ack}, 32'd0);
        vec_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R3: bypassed valid, capture one edge after rise
        valid_sync_bypass = 1'b1;
        vec_addr_hi = 30'h1234_5678;
        irq_entry = 1'b1;
        @(negedge clk) irq_entry = 1'b0;
        chk("R4", {31'd0, vec_ack}, 32'd1);
        vec_valid = 1'b1;
        expect_target({30'h1234_5678, 2'b00}, "R3");
        @(negedge clk) chk("R3", {31'd0, vec_ack}, 32'd0);
        vec_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule